// File: doc/BRIEF.md
# Maskable and Non-Maskable Interrupt Prioritizer

This block decides, for a small 8-bit controller core, whether an interrupt is taken at the current instruction boundary and which handler vector to use. It gathers two groups of requests. The non-maskable group is a set of internal fault and trap sources plus one external active-low request line. The maskable group is one external active-low request pin plus a set of internal peripheral requests. The core supplies its interrupt mask bit and an `accept` strobe that marks each cycle in which it can be interrupted. The block returns a take strobe and a 16-bit vector address in the range 0xFFC0 to 0xFFFF.

The block owns three pieces of state. The first is the mask for the external non-maskable line, which software can clear once and never set again. The second is an option bit that picks level or falling-edge sensing for the external maskable pin. The third is a 4-bit elevation field that lifts one maskable source above the fixed maskable order. The external maskable pin is first synchronized through two flops. In edge mode a falling edge latches a pending flag, which stays set until that request wins a take.

Top module: `irq_prioritizer`

## Requirements
- R1: After reset `x_mask` is 1, the option bit selects level sensing, the elevation field selects the pin (index 0), and with no requests `take` stays 0 even when `accept` is 1.
- R2: While `i_mask` is 1 no maskable source is taken. A maskable request that is still present is taken as soon as `i_mask` returns to 0.
- R3: The non-maskable order is `nmi_req[0]` highest down to `nmi_req[NMI_N-1]`, and `nmi_req[j]` uses vector 0xFFFC-2*j. The external non-maskable line uses 0xFFF4 and ranks below every internal non-maskable source and above every maskable source, whatever the value of `i_mask`.
- R4: While `x_mask` is 1 the external non-maskable line is ignored. A maskable request present at the same time wins.
- R5: A write with `x_wr`=1 and `x_val`=0 clears `x_mask`. A write with `x_val`=1 never sets it.
- R6: In level mode the pin requests while `irq_n` is low, seen two clock edges after the pin changes. It uses vector 0xFFF2.
- R7: In edge mode a falling edge of `irq_n` sets a pending request that remains after the pin returns high. It is cleared in the cycle in which the pin request is taken.
- R8: Maskable index 0 is the pin, and index k (1..14) is `msk_req[k-1]` with vector 0xFFF2-2*k. Without elevation, the lower index wins.
- R9: The elevation field value k (0..14) puts maskable index k above all other maskable sources. The value 15 leaves the fixed order.
- R10: Writes to the elevation field while `i_mask` is 0 are ignored.
- R11: `take` is `accept` AND any enabled request, so it lasts one cycle for each one-cycle `accept`. Requests that lose stay pending and win a later take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | 1 | External maskable request pin, active low |
| xirq_n | input | 1 | External non-maskable request, synchronous active-low level |
| nmi_req | input | NMI_N | Internal non-maskable requests |
| msk_req | input | MSK_N-1 | Internal maskable requests (maskable indices 1..MSK_N-1) |
| i_mask | input | 1 | Core interrupt mask bit |
| accept | input | 1 | Core can be interrupted this cycle |
| x_wr | input | 1 | Software write of the non-maskable line mask |
| x_val | input | 1 | Value written with `x_wr` |
| cfg_we | input | 1 | Write strobe for the pin sensing option |
| cfg_edge | input | 1 | Option value: 1 selects falling edge, 0 selects low level |
| prio_we | input | 1 | Write strobe for the elevation field |
| prio_sel | input | SEL_W | Elevation field value |
| take | output | 1 | Interrupt taken this cycle |
| vector | output | 16 | Vector address of the winning source |
| x_mask | output | 1 | Current mask of the external non-maskable line |

## Verification
The bound checker checks on every cycle that a take never happens without `accept`, that a take under `i_mask` always carries a non-maskable vector, that the external non-maskable line wins or is suppressed as `x_mask` dictates, that `x_mask` never returns to 1, and that elevation writes made with the mask open leave the field unchanged. Other behaviours need the bench's sequences: the two-edge synchronizer latency, a falling edge held as a sticky request and then cleared by its own take, the elevated source beating the pin, and a loser being served on the next accept.

// File: rtl/irq_prioritizer.sv
module irq_prioritizer #(
  parameter int          NMI_N   = 4,
  parameter int          MSK_N   = 15,
  parameter int          SEL_W   = 4,
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_n,
  input  logic             xirq_n,
  input  logic [NMI_N-1:0] nmi_req,
  input  logic [MSK_N-2:0] msk_req,
  input  logic             i_mask,
  input  logic             accept,
  input  logic             x_wr,
  input  logic             x_val,
  input  logic             cfg_we,
  input  logic             cfg_edge,
  input  logic             prio_we,
  input  logic [SEL_W-1:0] prio_sel,
  output logic             take,
  output logic [15:0]      vector,
  output logic             x_mask
);
  localparam logic [15:0] XVEC  = VEC_TOP - 16'(2 * NMI_N);
  localparam logic [15:0] MVEC0 = XVEC - 16'd2;

  logic             s1, s2, s3;
  logic             edge_q, edge_pend, x_q;
  logic [SEL_W-1:0] prio_q;
  logic             pin_req, fall, win, pin_win;
  logic [MSK_N-1:0] mreq;

  assign fall    = s3 & ~s2;
  assign pin_req = edge_q ? edge_pend : ~s2;
  assign mreq    = {msk_req, pin_req};
  assign x_mask  = x_q;
  assign take    = accept & win;

  always_comb begin
    win     = 1'b0;
    pin_win = 1'b0;
    vector  = 16'h0000;
    if (!i_mask) begin
      for (int k = MSK_N - 1; k >= 0; k--) begin
        if (mreq[k]) begin
          win     = 1'b1;
          vector  = MVEC0 - 16'(2 * k);
          pin_win = (k == 0);
        end
      end
      for (int k = 0; k < MSK_N; k++) begin
        if (prio_q == SEL_W'(k) && mreq[k]) begin
          vector  = MVEC0 - 16'(2 * k);
          pin_win = (k == 0);
        end
      end
    end
    if (!xirq_n && !x_q) begin
      win     = 1'b1;
      vector  = XVEC;
      pin_win = 1'b0;
    end
    for (int j = NMI_N - 1; j >= 0; j--) begin
      if (nmi_req[j]) begin
        win     = 1'b1;
        vector  = VEC_TOP - 16'(2 * j);
        pin_win = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= irq_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              edge_pend <= 1'b0;
    else if (!edge_q)        edge_pend <= 1'b0;
    else if (fall)           edge_pend <= 1'b1;
    else if (take && pin_win) edge_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= 1'b1;
      edge_q <= 1'b0;
      prio_q <= '0;
    end else begin
      if (x_wr && !x_val)     x_q    <= 1'b0;
      if (cfg_we)             edge_q <= cfg_edge;
      if (prio_we && i_mask)  prio_q <= prio_sel;
    end
  end
endmodule

module irq_prio_chk #(
  parameter int          NMI_N = 4,
  parameter int          SEL_W = 4,
  parameter logic [15:0] XVEC  = 16'hFFF4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             take,
  input logic [15:0]      vector,
  input logic             i_mask,
  input logic             xirq_n,
  input logic [NMI_N-1:0] nmi_req,
  input logic             x_mask,
  input logic             prio_we,
  input logic [SEL_W-1:0] prio_q
);
  assert_take_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> accept);
  assert_imask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && i_mask) |-> (vector >= XVEC));
  assert_xirq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && x_mask && nmi_req == '0) |-> (vector != XVEC));
  assert_xirq_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !xirq_n && !x_mask && nmi_req == '0) |-> (vector == XVEC));
  assert_x_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !x_mask |=> !x_mask);
  assert_prio_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_we && !i_mask) |=> $stable(prio_q));
endmodule

bind irq_prioritizer irq_prio_chk #(.NMI_N(NMI_N), .SEL_W(SEL_W), .XVEC(XVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .take(take), .vector(vector),
  .i_mask(i_mask), .xirq_n(xirq_n), .nmi_req(nmi_req), .x_mask(x_mask),
  .prio_we(prio_we), .prio_q(prio_q)
);

// File: tb/tb_irq_prioritizer.sv
module tb_irq_prioritizer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        irq_n = 1'b1, xirq_n = 1'b1, i_mask = 1'b1, accept = 1'b0;
  logic [3:0]  nmi_req = '0, prio_sel = '0;
  logic [13:0] msk_req = '0;
  logic        x_wr = 0, x_val = 0, cfg_we = 0, cfg_edge = 0, prio_we = 0;
  logic        take, x_mask;
  logic [15:0] vector;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  irq_prioritizer dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .xirq_n(xirq_n), .nmi_req(nmi_req),
    .msk_req(msk_req), .i_mask(i_mask), .accept(accept), .x_wr(x_wr), .x_val(x_val),
    .cfg_we(cfg_we), .cfg_edge(cfg_edge), .prio_we(prio_we), .prio_sel(prio_sel),
    .take(take), .vector(vector), .x_mask(x_mask)
  );

  // {i_mask, nmi_req, xirq_n, msk_req, exp_take, exp_vec}
  localparam int NT = 12;
  localparam logic [36:0] TBL [NT] = '{
    {1'b0, 4'h0, 1'b1, 14'h0000, 1'b0, 16'h0000},
    {1'b0, 4'h0, 1'b1, 14'h0001, 1'b1, 16'hFFF0},
    {1'b0, 4'h0, 1'b1, 14'h3FFF, 1'b1, 16'hFFF0},
    {1'b0, 4'h0, 1'b1, 14'h2000, 1'b1, 16'hFFD6},
    {1'b1, 4'h0, 1'b1, 14'h3FFF, 1'b0, 16'h0000},
    {1'b1, 4'h8, 1'b1, 14'h0000, 1'b1, 16'hFFF6},
    {1'b1, 4'hA, 1'b1, 14'h0000, 1'b1, 16'hFFFA},
    {1'b0, 4'hF, 1'b0, 14'h3FFF, 1'b1, 16'hFFFC},
    {1'b0, 4'h0, 1'b0, 14'h3FFF, 1'b1, 16'hFFF4},
    {1'b1, 4'h0, 1'b0, 14'h0000, 1'b1, 16'hFFF4},
    {1'b0, 4'h0, 1'b1, 14'h0100, 1'b1, 16'hFFE0},
    {1'b0, 4'h0, 1'b1, 14'h0104, 1'b1, 16'hFFEC}
  };

  task automatic check(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input bit et, input logic [15:0] ev);
    accept = 1'b1;
    #1;
    check(take == et && (!et || vector == ev), req, {take, vector}, {et, ev});
    accept = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check(x_mask == 1'b1, "R1", {16'h0, x_mask}, 17'h1);
    i_mask = 1'b0;
    probe("R1", 0, 16'h0);

    xirq_n = 1'b0;
    probe("R4", 0, 16'h0);
    msk_req = 14'h0001;
    probe("R4", 1, 16'hFFF0);
    xirq_n = 1'b1; msk_req = '0;

    x_wr = 1'b1; x_val = 1'b0; cyc(1);
    x_wr = 1'b0;
    check(x_mask == 1'b0, "R5", {16'h0, x_mask}, 17'h0);
    x_wr = 1'b1; x_val = 1'b1; cyc(1);
    x_wr = 1'b0; cyc(1);
    check(x_mask == 1'b0, "R5", {16'h0, x_mask}, 17'h0);

    for (int t = 0; t < NT; t++) begin
      {i_mask, nmi_req, xirq_n, msk_req} = TBL[t][36:17];
      probe(t < 5 ? "R8" : (t < 10 ? "R3" : "R8"), TBL[t][16], TBL[t][15:0]);
    end
    i_mask = 1'b0; nmi_req = '0; xirq_n = 1'b1; msk_req = '0;

    irq_n = 1'b0; cyc(1);
    probe("R6", 0, 16'h0);
    cyc(1);
    probe("R6", 1, 16'hFFF2);
    msk_req = 14'h3FFF;
    probe("R8", 1, 16'hFFF2);
    msk_req = '0;
    i_mask = 1'b1;
    probe("R2", 0, 16'h0);
    cyc(2);
    i_mask = 1'b0;
    probe("R2", 1, 16'hFFF2);
    irq_n = 1'b1; cyc(3);
    probe("R6", 0, 16'h0);

    i_mask = 1'b1; prio_we = 1'b1; prio_sel = 4'd5; cyc(1);
    prio_we = 1'b0; i_mask = 1'b0; msk_req = 14'h3FFF; irq_n = 1'b0; cyc(3);
    probe("R9", 1, 16'hFFE8);
    prio_we = 1'b1; prio_sel = 4'd3; cyc(1);
    prio_we = 1'b0;
    probe("R10", 1, 16'hFFE8);
    i_mask = 1'b1; prio_we = 1'b1; prio_sel = 4'd15; cyc(1);
    prio_we = 1'b0; i_mask = 1'b0;
    probe("R9", 1, 16'hFFF2);
    i_mask = 1'b1; prio_we = 1'b1; prio_sel = 4'd0; cyc(1);
    prio_we = 1'b0; i_mask = 1'b0; msk_req = '0; irq_n = 1'b1; cyc(3);

    cfg_we = 1'b1; cfg_edge = 1'b1; cyc(1);
    cfg_we = 1'b0; cyc(2);
    irq_n = 1'b0; cyc(2);
    irq_n = 1'b1; cyc(4);
    probe("R7", 1, 16'hFFF2);
    msk_req = 14'h0001;
    probe("R11", 1, 16'hFFF2);
    accept = 1'b1; cyc(1);
    accept = 1'b0;
    probe("R11", 1, 16'hFFF0);
    #1;
    check(take == 1'b0, "R11", {16'h0, take}, 17'h0);
    msk_req = '0;
    probe("R7", 0, 16'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule